// File: doc/BRIEF.md
# Single-Level Page Table Translator

This block turns a 32-bit virtual address into a physical address by looking up one entry in a flat page table. The table lives outside the block, in a memory reached through a synchronous read port with one cycle of latency. The virtual address splits into two parts. The upper 20 bits are the page index and select the table entry. The lower 12 bits are the byte offset inside a 4 KB page, and they pass straight through to the physical address.

Each table entry is a packed 24-bit word. It holds a residency flag and a 20-bit physical page number, which is stored as three sub-fields that the block puts back together. When the flag says the page is resident, the block returns the physical address with a one-cycle response pulse. When the flag says the page is not resident, the block raises a fault. The fault carries the page index and stays up until an external handler acknowledges it. The handler rewrites the entry through the block's update port, which the block forwards to the table's write port. After the acknowledge, the block reads the entry again and retries the lookup. Only one translation is in flight at a time.

Top module: `pt_xlat`

## Requirements
- R1: Bits 11:0 of `resp_paddr` equal bits 11:0 of the accepted virtual address.
- R2: The entry layout is as follows. Bit 23 is the residency flag (1 = resident). Bits 22:16 become physical address bits 31:25, bits 15:8 become bits 24:17, and bits 7:3 become bits 16:12. Bits 2:0 have no effect on the result.
- R3: `req_ready` is high only when the block is idle. A request presented while `req_ready` is low is not taken, so only one translation is in flight at a time.
- R4: For a resident entry, `resp_valid` is a single-cycle pulse. It becomes visible exactly three clock edges after the edge that accepted the request.
- R5: Each lookup drives `tbl_rd_en` for exactly one cycle, on the cycle after acceptance, with `tbl_rd_idx` equal to virtual address bits 31:12. The block uses `tbl_rd_data` on the following cycle.
- R6: For a non-resident entry, no response is produced. `fault_valid` rises and stays high, with `fault_idx` equal to virtual address bits 31:12, until `fault_ack` is seen.
- R7: When `fault_ack` is high during a fault, the same index is read again on the next cycle and the lookup is retried. If the entry is now resident, the response carries the new page number; if not, the fault is raised again.
- R8: `upd_en`, `upd_idx` and `upd_data` appear on `tbl_wr_en`, `tbl_wr_idx` and `tbl_wr_data` in the same cycle.
- R9: An update to the index being looked up takes effect in that lookup when it lands on the same edge as the table read or on the edge after it. This holds even though the table returns the old contents for a read on the edge of the write.
- R10: `fault_ack` has no effect when no fault is raised.
- R11: Reset is synchronous and active low. After any edge with `rst_n` low, `req_ready` is high and both `resp_valid` and `fault_valid` are low, and any pending translation is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| resp_valid | output | 1 | One-cycle pulse: `resp_paddr` is valid |
| resp_paddr | output | 32 | Translated physical address |
| fault_valid | output | 1 | Page not resident; waiting for the handler |
| fault_idx | output | 20 | Page index that faulted |
| fault_ack | input | 1 | Handler acknowledge; triggers the retry |
| tbl_rd_en | output | 1 | Table read strobe |
| tbl_rd_idx | output | 20 | Table read index |
| tbl_rd_data | input | 24 | Table entry, one cycle after the strobe |
| upd_en | input | 1 | Handler entry write |
| upd_idx | input | 20 | Handler write index |
| upd_data | input | 24 | Handler write entry |
| tbl_wr_en | output | 1 | Table write strobe |
| tbl_wr_idx | output | 20 | Table write index |
| tbl_wr_data | output | 24 | Table write entry |

## Verification
A wrong field slice in the entry decode shows up as wrong upper address bits on the very first response from an entry whose sub-fields differ. Filling the unused bits with ones exposes any decode that leaks them. A control state that slips by one cycle moves the response pulse off its three-edge slot, or fires the read strobe at the wrong time, and the mismatch appears in the first transaction. A stale forwarding register, or a missing one, only shows after a fault. The retried lookup then faults again or returns the old page, within a few cycles of the acknowledge. A state not cleared by reset shows as a lingering fault or a missing ready in the cycle after reset.

// File: rtl/pt_xlat_pkg.sv
// Package pt_xlat_pkg
// Holds the control state encoding shared by the translator's controller and
// its checker. It assumes nothing about widths; those stay module parameters.
package pt_xlat_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,  // waiting for a request
        ST_ISSUE = 3'd1,  // table read strobe driven
        ST_WAIT  = 3'd2,  // table data returning, entry captured
        ST_CHECK = 3'd3,  // captured entry decoded, residency tested
        ST_RESP  = 3'd4,  // response pulse
        ST_FAULT = 3'd5   // waiting for the handler's acknowledge
    } xlat_st_e;

endpackage

// File: rtl/pt_req_reg.sv
// Module pt_req_reg
// Captures an accepted virtual address and splits it into page index and
// in-page offset. Assumes the offset occupies the low OFF_W bits and the index
// the remaining upper bits. The fields stay held until the next load.
module pt_req_reg #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    localparam int IDX_W = VA_W - OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [VA_W-1:0]  vaddr,
    output logic [IDX_W-1:0] idx_q,
    output logic [OFF_W-1:0] off_q
);

    // Hold the split request fields for the whole translation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            off_q <= '0;
        end else if (load) begin
            idx_q <= vaddr[VA_W-1 -: IDX_W];
            off_q <= vaddr[OFF_W-1:0];
        end
    end

endmodule

// File: rtl/pt_entry_fwd.sv
// Module pt_entry_fwd
// Chooses the entry a lookup uses. The table read returns contents from before
// any write on the same edge, so a handler update to the looked-up index on
// the read edge is held here. An update on the landing edge is taken directly.
// Assumes rd_slot is the cycle of the read strobe and land_slot the cycle after.
module pt_entry_fwd #(
    parameter int IDX_W = 20,
    parameter int ENT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_slot,
    input  logic             land_slot,
    input  logic [IDX_W-1:0] look_idx,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [ENT_W-1:0] upd_data,
    input  logic [ENT_W-1:0] rd_data,
    output logic [ENT_W-1:0] ent_sel
);

    logic             hit_now;
    logic             byp_v_q;
    logic [ENT_W-1:0] byp_d_q;

    // Detect an update aimed at the entry under lookup
    always_comb hit_now = upd_en && (upd_idx == look_idx);

    // Hold an update that coincides with the table read edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byp_v_q <= 1'b0;
            byp_d_q <= '0;
        end else if (rd_slot) begin
            byp_v_q <= hit_now;
            byp_d_q <= upd_data;
        end else if (!land_slot) begin
            byp_v_q <= 1'b0;
        end
    end

    // Newest source wins: landing-edge update, held update, then table data
    always_comb begin
        if (land_slot && hit_now) ent_sel = upd_data;
        else if (byp_v_q)         ent_sel = byp_d_q;
        else                      ent_sel = rd_data;
    end

endmodule

// File: rtl/pt_entry_decode.sv
// Module pt_entry_decode
// Unpacks a table entry: residency flag on the top bit, then three page number
// fields (high, middle, low), then unused padding at the bottom. Joins the
// fields above the offset to form the physical address.
// Assumes ENT_W equals 1 + HI_W + MID_W + LO_W + PAD_W.
module pt_entry_decode #(
    parameter int HI_W  = 7,
    parameter int MID_W = 8,
    parameter int LO_W  = 5,
    parameter int PAD_W = 3,
    parameter int OFF_W = 12,
    localparam int ENT_W = 1 + HI_W + MID_W + LO_W + PAD_W,
    localparam int PA_W  = HI_W + MID_W + LO_W + OFF_W
) (
    input  logic [ENT_W-1:0] ent,
    input  logic [OFF_W-1:0] off,
    output logic             ent_valid,
    output logic [PA_W-1:0]  paddr
);

    localparam int HI_TOP  = ENT_W - 2;
    localparam int MID_TOP = HI_TOP - HI_W;

    logic [HI_W-1:0]  f_hi;
    logic [MID_W-1:0] f_mid;
    logic [LO_W-1:0]  f_lo;

    // Slice the packed fields out of the entry
    always_comb begin
        ent_valid = ent[ENT_W-1];
        f_hi      = ent[HI_TOP -: HI_W];
        f_mid     = ent[MID_TOP -: MID_W];
        f_lo      = ent[PAD_W +: LO_W];
        paddr     = {f_hi, f_mid, f_lo, off};
    end

    // Padding bits carry no meaning; tie them off only when they exist
    generate
        if (PAD_W > 0) begin : g_pad
            logic pad_unused;
            always_comb pad_unused = ^ent[PAD_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/pt_xlat_ctrl.sv
// Module pt_xlat_ctrl
// Sequences one translation: accept, read strobe, data landing, residency
// check, then either a response pulse or a fault held until acknowledged,
// after which the read is issued again. Assumes ent_valid reflects the entry
// captured on the landing cycle.
module pt_xlat_ctrl
    import pt_xlat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic ent_valid,
    input  logic fault_ack,
    output logic req_ready,
    output logic load_req,
    output logic rd_slot,
    output logic land_slot,
    output logic load_pa,
    output logic resp_valid,
    output logic fault_valid
);

    xlat_st_e st_q;
    xlat_st_e st_d;

    // State register with synchronous reset to idle
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next-state rules for one outstanding translation
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:  if (req_valid) st_d = ST_ISSUE;
            ST_ISSUE: st_d = ST_WAIT;
            ST_WAIT:  st_d = ST_CHECK;
            ST_CHECK: st_d = ent_valid ? ST_RESP : ST_FAULT;
            ST_RESP:  st_d = ST_IDLE;
            ST_FAULT: if (fault_ack) st_d = ST_ISSUE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // Decode state into strobes for datapath and ports
    always_comb begin
        req_ready   = (st_q == ST_IDLE);
        load_req    = (st_q == ST_IDLE) && req_valid;
        rd_slot     = (st_q == ST_ISSUE);
        land_slot   = (st_q == ST_WAIT);
        load_pa     = (st_q == ST_CHECK) && ent_valid;
        resp_valid  = (st_q == ST_RESP);
        fault_valid = (st_q == ST_FAULT);
    end

endmodule

// File: rtl/pt_xlat.sv
// Module pt_xlat
// Top of the single-level page table translator. Splits the virtual address,
// reads one entry from an external table, forwards handler updates to that
// table, and either answers with the physical address or raises a fault and
// retries after acknowledge. Assumes the table answers a read one cycle after
// the strobe, returning contents from before any write on that same edge.
module pt_xlat #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int HI_W  = 7,
    parameter int MID_W = 8,
    parameter int LO_W  = 5,
    parameter int PAD_W = 3,
    localparam int IDX_W = VA_W - OFF_W,
    localparam int ENT_W = 1 + HI_W + MID_W + LO_W + PAD_W,
    localparam int PA_W  = HI_W + MID_W + LO_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             resp_valid,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             fault_valid,
    output logic [IDX_W-1:0] fault_idx,
    input  logic             fault_ack,
    output logic             tbl_rd_en,
    output logic [IDX_W-1:0] tbl_rd_idx,
    input  logic [ENT_W-1:0] tbl_rd_data,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [ENT_W-1:0] upd_data,
    output logic             tbl_wr_en,
    output logic [IDX_W-1:0] tbl_wr_idx,
    output logic [ENT_W-1:0] tbl_wr_data
);

    logic             load_req;
    logic             rd_slot;
    logic             land_slot;
    logic             load_pa;
    logic             ent_valid;
    logic [IDX_W-1:0] idx_q;
    logic [OFF_W-1:0] off_q;
    logic [ENT_W-1:0] ent_sel;
    logic [ENT_W-1:0] ent_q;
    logic [PA_W-1:0]  pa_d;
    logic [PA_W-1:0]  pa_q;

    pt_xlat_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .ent_valid   (ent_valid),
        .fault_ack   (fault_ack),
        .req_ready   (req_ready),
        .load_req    (load_req),
        .rd_slot     (rd_slot),
        .land_slot   (land_slot),
        .load_pa     (load_pa),
        .resp_valid  (resp_valid),
        .fault_valid (fault_valid)
    );

    pt_req_reg #(.VA_W(VA_W), .OFF_W(OFF_W)) u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_req),
        .vaddr (req_vaddr),
        .idx_q (idx_q),
        .off_q (off_q)
    );

    pt_entry_fwd #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_fwd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_slot   (rd_slot),
        .land_slot (land_slot),
        .look_idx  (idx_q),
        .upd_en    (upd_en),
        .upd_idx   (upd_idx),
        .upd_data  (upd_data),
        .rd_data   (tbl_rd_data),
        .ent_sel   (ent_sel)
    );

    pt_entry_decode #(
        .HI_W(HI_W), .MID_W(MID_W), .LO_W(LO_W), .PAD_W(PAD_W), .OFF_W(OFF_W)
    ) u_dec (
        .ent       (ent_q),
        .off       (off_q),
        .ent_valid (ent_valid),
        .paddr     (pa_d)
    );

    // Capture the chosen entry on the landing cycle
    always_ff @(posedge clk) begin
        if (!rst_n)         ent_q <= '0;
        else if (land_slot) ent_q <= ent_sel;
    end

    // Register the physical address when the entry proves resident
    always_ff @(posedge clk) begin
        if (!rst_n)       pa_q <= '0;
        else if (load_pa) pa_q <= pa_d;
    end

    // Drive response, fault, and table read ports from held state
    always_comb begin
        resp_paddr = pa_q;
        fault_idx  = idx_q;
        tbl_rd_en  = rd_slot;
        tbl_rd_idx = idx_q;
    end

    // Pass handler updates straight to the table write port
    always_comb begin
        tbl_wr_en   = upd_en;
        tbl_wr_idx  = upd_idx;
        tbl_wr_data = upd_data;
    end

endmodule

// File: rtl/pt_xlat_chk.sv
// Module pt_xlat_chk
// Port-level protocol checks for pt_xlat, attached by bind. Assumes the
// default single-outstanding sequencing of the translator.
module pt_xlat_chk #(
    parameter int VA_W  = 32,
    parameter int IDX_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             resp_valid,
    input logic             fault_valid,
    input logic [IDX_W-1:0] fault_idx,
    input logic             fault_ack,
    input logic             tbl_rd_en,
    input logic [IDX_W-1:0] tbl_rd_idx
);

    logic was_rst_q;

    // Remember whether the previous edge saw reset
    always_ff @(posedge clk) was_rst_q <= !rst_n;

    // R11
    always_comb begin
        if (was_rst_q == 1'b1 && rst_n == 1'b1) begin
            reset_idle_chk: assert (req_ready && !resp_valid && !fault_valid)
                else $error("block not idle after reset");
        end
    end

    // R4
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R4
    resp_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(tbl_rd_en, 3));

    // R3
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, resp_valid, fault_valid, tbl_rd_en}));

    // R5
    rd_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=>
            (tbl_rd_en && tbl_rd_idx == $past(req_vaddr[VA_W-1 -: IDX_W])));

    // R5
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd_en |=> !tbl_rd_en);

    // R6
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && !fault_ack) |=> (fault_valid && $stable(fault_idx)));

    // R7
    fault_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && fault_ack) |=>
            (tbl_rd_en && tbl_rd_idx == $past(fault_idx)));

    // R10
    ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid && fault_ack) |=> req_ready);

endmodule

bind pt_xlat pt_xlat_chk #(.VA_W(VA_W), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_vaddr   (req_vaddr),
    .resp_valid  (resp_valid),
    .fault_valid (fault_valid),
    .fault_idx   (fault_idx),
    .fault_ack   (fault_ack),
    .tbl_rd_en   (tbl_rd_en),
    .tbl_rd_idx  (tbl_rd_idx)
);

// File: tb/pt_xlat_tb.sv
`timescale 1ns/1ps
// Scoreboard bench for pt_xlat: driver tasks queue expected addresses,
// a negedge monitor pops and compares each response.
module pt_xlat_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_vaddr;
    logic        resp_valid;
    logic [31:0] resp_paddr;
    logic        fault_valid;
    logic [19:0] fault_idx;
    logic        fault_ack;
    logic        tbl_rd_en;
    logic [19:0] tbl_rd_idx;
    logic [23:0] tbl_rd_data;
    logic        upd_en;
    logic [19:0] upd_idx;
    logic [23:0] upd_data;
    logic        tbl_wr_en;
    logic [19:0] tbl_wr_idx;
    logic [23:0] tbl_wr_data;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [31:0] pa;
        int          acc;
        bit          lat;
    } exp_t;
    exp_t exp_q[$];

    logic [23:0] mem [bit [19:0]];
    logic [23:0] rd_q = '0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pt_xlat u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr),
        .fault_valid(fault_valid), .fault_idx(fault_idx), .fault_ack(fault_ack),
        .tbl_rd_en(tbl_rd_en), .tbl_rd_idx(tbl_rd_idx), .tbl_rd_data(tbl_rd_data),
        .upd_en(upd_en), .upd_idx(upd_idx), .upd_data(upd_data),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_data(tbl_wr_data)
    );

    // Table model: read returns contents from before a same-edge write
    always @(posedge clk) begin
        if (tbl_rd_en) rd_q <= mem.exists(tbl_rd_idx) ? mem[tbl_rd_idx] : 24'h0;
        if (tbl_wr_en) mem[tbl_wr_idx] = tbl_wr_data;
    end
    assign tbl_rd_data = rd_q;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] mk_ent(input bit v, input logic [19:0] ppn,
                                           input logic [2:0] pad);
        return {v, ppn[19:13], ppn[12:5], ppn[4:0], pad};
    endfunction

    // Monitor: compare each response against the oldest queued expectation
    always @(negedge clk) begin
        exp_t e;
        if (rst_n === 1'b1 && resp_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected response", resp_paddr, 0);
            end else begin
                e = exp_q.pop_front();
                chk(resp_paddr == e.pa, "R1 R2 physical address", resp_paddr, e.pa);
                if (e.lat) chk(cyc - e.acc == 3, "R4 hit latency", cyc - e.acc, 3);
            end
        end
    end

    task automatic send(input logic [31:0] va, input logic [31:0] pa, input bit lat);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        e.pa = pa; e.acc = cyc; e.lat = lat;
        exp_q.push_back(e);
        chk(req_ready == 1'b0, "R3 ready low while busy", req_ready, 0);
        chk(tbl_rd_en && tbl_rd_idx == va[31:12], "R5 read strobe index", tbl_rd_idx, va[31:12]);
    endtask

    task automatic drain(input string tag);
        for (int k = 0; k < 30 && exp_q.size() != 0; k++) @(negedge clk);
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    task automatic miss(input logic [31:0] va, input logic [19:0] ppn, input int mode);
        send(va, {ppn, va[11:0]}, 1'b0);
        for (int k = 0; k < 10 && !fault_valid; k++) @(negedge clk);
        chk(fault_valid, "R6 fault raised", fault_valid, 1);
        chk(fault_idx == va[31:12], "R6 fault index", fault_idx, va[31:12]);
        repeat (3) @(negedge clk);
        chk(fault_valid && !resp_valid, "R6 fault held without response",
            {fault_valid, resp_valid}, 2'b10);
        fault_ack = 1'b1;
        if (mode == 0) begin
            upd_en = 1'b1; upd_idx = va[31:12]; upd_data = mk_ent(1'b1, ppn, 3'b111);
        end
        @(negedge clk);
        fault_ack = 1'b0;
        upd_en = 1'b0;
        if (mode == 2) @(negedge clk);
        if (mode != 0) begin
            upd_en = 1'b1; upd_idx = va[31:12]; upd_data = mk_ent(1'b1, ppn, 3'b010);
            @(negedge clk);
            upd_en = 1'b0;
        end
        drain("R7 retry delivers response");
        chk(!fault_valid, "R9 no second fault", fault_valid, 0);
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R7 watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; fault_ack = 1'b0;
        upd_en = 1'b0; upd_idx = '0; upd_data = '0;
        mem[20'h00001] = mk_ent(1'b1, 20'hABCDE, 3'b101);
        mem[20'hFFFFF] = mk_ent(1'b1, 20'h00001, 3'b111);
        mem[20'h12345] = mk_ent(1'b1, 20'h80000, 3'b000);
        mem[20'h00000] = mk_ent(1'b1, 20'h7FFFF, 3'b111);
        mem[20'h0DEAD] = mk_ent(1'b0, 20'h11111, 3'b000);
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(req_ready == 1'b1, "R11 ready in reset", req_ready, 1);
        chk(resp_valid == 1'b0, "R11 no response in reset", resp_valid, 0);
        chk(fault_valid == 1'b0, "R11 no fault in reset", fault_valid, 0);
        rst_n = 1'b1;

        // R1 R2 R4: hits with varied offsets and page numbers
        send(32'h0000_1000, 32'hABCD_E000, 1'b1);
        send(32'h0000_1FFF, 32'hABCD_EFFF, 1'b1);
        send(32'hFFFF_F7A5, 32'h0000_17A5, 1'b1);
        send(32'h1234_5C3C, 32'h8000_0C3C, 1'b1);
        send(32'h0000_0001, 32'h7FFF_F001, 1'b1);
        drain("R4 hits answered");

        // R3: request held while busy is not taken
        send(32'h0000_1234, 32'hABCD_E234, 1'b1);
        req_valid = 1'b1; req_vaddr = 32'hFFFF_F000;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (8) @(negedge clk);
        chk(exp_q.size() == 0 && req_ready, "R3 busy request ignored", exp_q.size(), 0);

        // R10: acknowledge with no fault
        fault_ack = 1'b1;
        @(negedge clk);
        fault_ack = 1'b0;
        chk(req_ready && !fault_valid && !resp_valid, "R10 idle ack no effect",
            {req_ready, fault_valid, resp_valid}, 3'b100);
        send(32'h0000_1ABC, 32'hABCD_EABC, 1'b1);
        fault_ack = 1'b1;
        @(negedge clk);
        fault_ack = 1'b0;
        drain("R10 ack during hit harmless");

        // R6 R7 R8: miss resolved with update on the acknowledge edge
        miss(32'h0DEA_D456, 20'h22222, 0);
        send(32'h0DEA_D000, 32'h2222_2000, 1'b1);
        drain("R8 update reached table");

        // R9: update lands on the retry read edge, then on the landing edge
        miss(32'h0BEE_F010, 20'h33333, 1);
        miss(32'h0CAF_E020, 20'h44444, 2);

        // R11: reset abandons a pending fault
        send(32'h0BAD_0000, 32'h0, 1'b0);
        for (int k = 0; k < 10 && !fault_valid; k++) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!fault_valid && !resp_valid && req_ready, "R11 reset clears fault",
            {fault_valid, resp_valid, req_ready}, 3'b001);
        rst_n = 1'b1;
        void'(exp_q.pop_back());
        repeat (3) @(negedge clk);
        chk(!resp_valid && !fault_valid, "R11 nothing resumes after reset",
            {resp_valid, fault_valid}, 0);
        send(32'h0000_1555, 32'hABCD_E555, 1'b1);
        drain("R11 hit after reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule